// File: doc/BRIEF.md
# UART Software Flow Control Engine

This block sits between a UART receive deserializer and the receive FIFO, and beside the transmit path. It carries out in-band software flow control using two programmable pairs of resume/pause characters. A 4-bit control field chooses how the block acts. The upper two bits choose which characters the block asks the transmitter to insert as the local FIFO fills and drains. The lower two bits choose which received characters are recognised as pause or resume commands from the far end. Recognised command characters are consumed: they never reach the FIFO. A received pause command raises a halt flag for the local transmitter, and a received resume command drops it.

A separate special-character mode watches every received character for the value in the second pause register. A matching character is still stored, and a sticky interrupt flag is raised until a read strobe clears it. While this mode is on, flow-control matching is off. Received characters are expected at least one idle clock apart, which any serial line rate ensures. FIFO writes appear one cycle after the receive strobe.

Top module: `uart_swflow_ctrl`

## Requirements
- R1: After reset, fifoWrEn, txHalt, txInsValid and specIrq are all 0.
- R2: With rxMode (ctrlMode[1:0]) = 00 and specialEn = 0, every received character is written to the FIFO unchanged one cycle after rxValid, including values equal to any flow-control register.
- R3: With rxMode = 10 (pair 1: xonChar1/xoffChar1) or 01 (pair 2: xonChar2/xoffChar2), a received pause character of the selected pair is consumed and sets txHalt, and a received resume character of that pair is consumed and clears txHalt. Every other character, including those of the unselected pair, is written as data.
- R4: With rxMode = 11, the pair of consecutive characters xoffChar1 then xoffChar2 is consumed and sets txHalt, and xonChar1 then xonChar2 is consumed and clears txHalt. A lone second character is data.
- R5: With rxMode = 11, when a held first character is followed by a character that does not complete the pair, the held character is written one cycle after the second rxValid, and the second character is written one cycle after that.
- R6: With specialEn = 1, a received character equal to xoffChar2 is written to the FIFO and sets specIrq. No character is consumed, and txHalt stays 0.
- R7: specIrq stays at 1 until a cycle with specRead = 1 and no new match. It then clears on the following cycle. A new match in the same cycle as specRead takes precedence.
- R8: Whenever rxMode = 00 or specialEn = 1, txHalt is 0 from the next cycle on.
- R9: With txMode (ctrlMode[3:2]) non-zero, when fifoLevel first reaches hiTrig or above, the block offers pause characters on txInsChar with txInsValid. Mode 10 offers xoffChar1, mode 01 offers xoffChar2, and mode 11 offers xoffChar1 and then xoffChar2. Each character is held stable until txInsReady is 1.
- R10: After a pause request, the first time fifoLevel is below loTrig the resume characters are offered in the same way. Neither request repeats while the level stays on the same side.
- R11: With txMode = 00, no insertion request is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxValid | input | 1 | Received character strobe |
| rxData | input | CHAR_W | Received character |
| ctrlMode | input | 4 | [3:2] transmit mode, [1:0] receive mode |
| specialEn | input | 1 | Special-character detect mode |
| xonChar1 | input | CHAR_W | First resume character |
| xonChar2 | input | CHAR_W | Second resume character |
| xoffChar1 | input | CHAR_W | First pause character |
| xoffChar2 | input | CHAR_W | Second pause character, also the special character |
| fifoLevel | input | LVL_W | Receive FIFO fill level |
| hiTrig | input | LVL_W | Level that triggers a pause request |
| loTrig | input | LVL_W | Level below which a resume request is made |
| specRead | input | 1 | Clears the special-character flag |
| txInsReady | input | 1 | Transmitter accepts the offered character |
| fifoWrEn | output | 1 | Receive FIFO write enable |
| fifoWrData | output | CHAR_W | Receive FIFO write data |
| txHalt | output | 1 | Local transmitter must pause |
| txInsValid | output | 1 | Flow-control character offered for insertion |
| txInsChar | output | CHAR_W | Offered flow-control character |
| specIrq | output | 1 | Sticky special-character flag |

## Verification
The hardest situation to reach is the two-character case in paired mode where the second character breaks the sequence. The held character and the breaking character must then reach the FIFO in two successive cycles and in their original order. The stimulus first sends a lone first resume character and checks that nothing is written. It then sends an unrelated character and checks the two writes on consecutive cycles. The two-character transmit request also needs care: txInsReady is held low for a cycle to prove that the offered character stays stable, and is then raised to step through both characters.

// File: rtl/swflow_pkg.sv
package swflow_pkg;

  typedef enum logic [1:0] {
    SEL_ON1  = 2'd0,
    SEL_ON2  = 2'd1,
    SEL_OFF1 = 2'd2,
    SEL_OFF2 = 2'd3
  } charSel_e;

  typedef enum logic [1:0] {
    PEND_NONE = 2'd0,
    PEND_ON   = 2'd1,
    PEND_OFF  = 2'd2
  } pend_e;

  typedef struct packed {
    logic xon1;
    logic xon2;
    logic xoff1;
    logic xoff2;
  } match_t;

  typedef struct packed {
    logic writeCur;
    logic writeHeld;
    logic holdCur;
    logic loadReplay;
  } rxStrobe_t;

endpackage

// File: rtl/swflow_datapath.sv
module swflow_datapath
  import swflow_pkg::*;
#(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CHAR_W-1:0] rxData,
  input  logic [CHAR_W-1:0] xonChar1,
  input  logic [CHAR_W-1:0] xonChar2,
  input  logic [CHAR_W-1:0] xoffChar1,
  input  logic [CHAR_W-1:0] xoffChar2,
  input  rxStrobe_t         strb,
  input  charSel_e          txSel,
  output match_t            match,
  output logic              fifoWrEn,
  output logic [CHAR_W-1:0] fifoWrData,
  output logic [CHAR_W-1:0] txInsChar
);

  logic [CHAR_W-1:0] heldChar;
  logic [CHAR_W-1:0] replayChar;
  logic              replayPend;

  // full-width equality: register bit 0 meets received bit 0 (LSB first on the line)
  always_comb begin
    match.xon1  = (rxData == xonChar1);
    match.xon2  = (rxData == xonChar2);
    match.xoff1 = (rxData == xoffChar1);
    match.xoff2 = (rxData == xoffChar2);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldChar   <= '0;
      replayChar <= '0;
      replayPend <= 1'b0;
      fifoWrEn   <= 1'b0;
      fifoWrData <= '0;
    end else begin
      if (strb.holdCur) heldChar <= rxData;
      if (strb.loadReplay) replayChar <= rxData;
      replayPend <= strb.loadReplay;
      fifoWrEn   <= strb.writeCur | strb.writeHeld | replayPend;
      if (strb.writeHeld)     fifoWrData <= heldChar;
      else if (replayPend)    fifoWrData <= replayChar;
      else if (strb.writeCur) fifoWrData <= rxData;
    end
  end

  always_comb begin
    unique case (txSel)
      SEL_ON1:  txInsChar = xonChar1;
      SEL_ON2:  txInsChar = xonChar2;
      SEL_OFF1: txInsChar = xoffChar1;
      default:  txInsChar = xoffChar2;
    endcase
  end

endmodule

// File: rtl/swflow_control.sv
module swflow_control
  import swflow_pkg::*;
#(
  parameter int LVL_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxValid,
  input  logic [3:0]       ctrlMode,
  input  logic             specialEn,
  input  match_t           match,
  input  logic [LVL_W-1:0] fifoLevel,
  input  logic [LVL_W-1:0] hiTrig,
  input  logic [LVL_W-1:0] loTrig,
  input  logic             specRead,
  input  logic             txInsReady,
  output rxStrobe_t        strb,
  output charSel_e         txSel,
  output logic             txHalt,
  output logic             specIrq,
  output logic             txInsValid
);

  localparam logic [1:0] MODE_NONE  = 2'b00;
  localparam logic [1:0] MODE_PAIR1 = 2'b10;
  localparam logic [1:0] MODE_PAIR2 = 2'b01;
  localparam logic [1:0] MODE_BOTH  = 2'b11;

  logic [1:0] rxMode;
  logic [1:0] txMode;
  logic       rxOn;
  logic       setHalt;
  logic       clrHalt;
  logic       setSpec;
  pend_e      pend;
  pend_e      pendNext;

  assign rxMode = ctrlMode[1:0];
  assign txMode = ctrlMode[3:2];
  assign rxOn   = !specialEn && (rxMode != MODE_NONE);

  // receive-side decision
  always_comb begin
    strb     = '0;
    setHalt  = 1'b0;
    clrHalt  = 1'b0;
    setSpec  = 1'b0;
    pendNext = pend;
    if (!rxOn || rxMode != MODE_BOTH) pendNext = PEND_NONE;
    if (rxValid) begin
      if (specialEn) begin
        strb.writeCur = 1'b1;
        setSpec       = match.xoff2;
      end else begin
        unique case (rxMode)
          MODE_PAIR1: begin
            if (match.xoff1)     setHalt = 1'b1;
            else if (match.xon1) clrHalt = 1'b1;
            else                 strb.writeCur = 1'b1;
          end
          MODE_PAIR2: begin
            if (match.xoff2)     setHalt = 1'b1;
            else if (match.xon2) clrHalt = 1'b1;
            else                 strb.writeCur = 1'b1;
          end
          MODE_BOTH: begin
            unique case (pend)
              PEND_ON: begin
                pendNext = PEND_NONE;
                if (match.xon2) clrHalt = 1'b1;
                else begin
                  strb.writeHeld  = 1'b1;
                  strb.loadReplay = 1'b1;
                end
              end
              PEND_OFF: begin
                pendNext = PEND_NONE;
                if (match.xoff2) setHalt = 1'b1;
                else begin
                  strb.writeHeld  = 1'b1;
                  strb.loadReplay = 1'b1;
                end
              end
              default: begin
                if (match.xoff1) begin
                  strb.holdCur = 1'b1;
                  pendNext     = PEND_OFF;
                end else if (match.xon1) begin
                  strb.holdCur = 1'b1;
                  pendNext     = PEND_ON;
                end else begin
                  strb.writeCur = 1'b1;
                end
              end
            endcase
          end
          default: strb.writeCur = 1'b1;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pend    <= PEND_NONE;
      txHalt  <= 1'b0;
      specIrq <= 1'b0;
    end else begin
      pend <= pendNext;
      if (!rxOn)        txHalt <= 1'b0;
      else if (setHalt) txHalt <= 1'b1;
      else if (clrHalt) txHalt <= 1'b0;
      if (setSpec)       specIrq <= 1'b1;
      else if (specRead) specIrq <= 1'b0;
    end
  end

  // transmit-side insertion requests
  logic       throttled;
  logic       sendOff;
  logic       sendIdx;
  logic [1:0] sendMode;
  logic       useSecond;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      throttled  <= 1'b0;
      txInsValid <= 1'b0;
      sendOff    <= 1'b0;
      sendIdx    <= 1'b0;
      sendMode   <= MODE_NONE;
    end else if (txInsValid) begin
      if (txInsReady) begin
        if (sendMode == MODE_BOTH && !sendIdx) sendIdx <= 1'b1;
        else txInsValid <= 1'b0;
      end
    end else if (txMode == MODE_NONE) begin
      throttled <= 1'b0;
    end else if (!throttled && fifoLevel >= hiTrig) begin
      throttled  <= 1'b1;
      txInsValid <= 1'b1;
      sendOff    <= 1'b1;
      sendIdx    <= 1'b0;
      sendMode   <= txMode;
    end else if (throttled && fifoLevel < loTrig) begin
      throttled  <= 1'b0;
      txInsValid <= 1'b1;
      sendOff    <= 1'b0;
      sendIdx    <= 1'b0;
      sendMode   <= txMode;
    end
  end

  assign useSecond = (sendMode == MODE_PAIR2) || (sendMode == MODE_BOTH && sendIdx);

  always_comb begin
    if (sendOff) txSel = useSecond ? SEL_OFF2 : SEL_OFF1;
    else         txSel = useSecond ? SEL_ON2  : SEL_ON1;
  end

endmodule

// File: rtl/uart_swflow_ctrl.sv
module uart_swflow_ctrl
  import swflow_pkg::*;
#(
  parameter int CHAR_W = 8,
  parameter int LVL_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxValid,
  input  logic [CHAR_W-1:0] rxData,
  input  logic [3:0]        ctrlMode,
  input  logic              specialEn,
  input  logic [CHAR_W-1:0] xonChar1,
  input  logic [CHAR_W-1:0] xonChar2,
  input  logic [CHAR_W-1:0] xoffChar1,
  input  logic [CHAR_W-1:0] xoffChar2,
  input  logic [LVL_W-1:0]  fifoLevel,
  input  logic [LVL_W-1:0]  hiTrig,
  input  logic [LVL_W-1:0]  loTrig,
  input  logic              specRead,
  input  logic              txInsReady,
  output logic              fifoWrEn,
  output logic [CHAR_W-1:0] fifoWrData,
  output logic              txHalt,
  output logic              txInsValid,
  output logic [CHAR_W-1:0] txInsChar,
  output logic              specIrq
);

  match_t    match;
  rxStrobe_t strb;
  charSel_e  txSel;

  swflow_control #(.LVL_W(LVL_W)) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .rxValid    (rxValid),
    .ctrlMode   (ctrlMode),
    .specialEn  (specialEn),
    .match      (match),
    .fifoLevel  (fifoLevel),
    .hiTrig     (hiTrig),
    .loTrig     (loTrig),
    .specRead   (specRead),
    .txInsReady (txInsReady),
    .strb       (strb),
    .txSel      (txSel),
    .txHalt     (txHalt),
    .specIrq    (specIrq),
    .txInsValid (txInsValid)
  );

  swflow_datapath #(.CHAR_W(CHAR_W)) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .rxData     (rxData),
    .xonChar1   (xonChar1),
    .xonChar2   (xonChar2),
    .xoffChar1  (xoffChar1),
    .xoffChar2  (xoffChar2),
    .strb       (strb),
    .txSel      (txSel),
    .match      (match),
    .fifoWrEn   (fifoWrEn),
    .fifoWrData (fifoWrData),
    .txInsChar  (txInsChar)
  );

endmodule

// File: rtl/swflow_checker.sv
module swflow_checker #(
  parameter int CHAR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              rxValid,
  input logic [CHAR_W-1:0] rxData,
  input logic [3:0]        ctrlMode,
  input logic              specialEn,
  input logic [CHAR_W-1:0] xoffChar2,
  input logic              specRead,
  input logic              txInsReady,
  input logic              fifoWrEn,
  input logic [CHAR_W-1:0] fifoWrData,
  input logic              txHalt,
  input logic              txInsValid,
  input logic [CHAR_W-1:0] txInsChar,
  input logic              specIrq
);

  p_pass_mode0_r2: assert property (@(posedge clk) disable iff (!rstN)
    rxValid && !specialEn && ctrlMode[1:0] == 2'b00 |=> fifoWrEn && fifoWrData == $past(rxData));

  p_special_store_r6: assert property (@(posedge clk) disable iff (!rstN)
    rxValid && specialEn && rxData == xoffChar2 |=> fifoWrEn && specIrq);

  p_spec_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    specIrq && !specRead |=> specIrq);

  p_halt_off_r8: assert property (@(posedge clk) disable iff (!rstN)
    specialEn || ctrlMode[1:0] == 2'b00 |=> !txHalt);

  p_ins_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    txInsValid && !txInsReady |=> txInsValid && $stable(txInsChar));

  p_no_request_r11: assert property (@(posedge clk) disable iff (!rstN)
    ctrlMode[3:2] == 2'b00 && !txInsValid |=> !txInsValid);

endmodule

bind uart_swflow_ctrl swflow_checker #(.CHAR_W(CHAR_W)) i_chk (
  .clk        (clk),
  .rstN       (rstN),
  .rxValid    (rxValid),
  .rxData     (rxData),
  .ctrlMode   (ctrlMode),
  .specialEn  (specialEn),
  .xoffChar2  (xoffChar2),
  .specRead   (specRead),
  .txInsReady (txInsReady),
  .fifoWrEn   (fifoWrEn),
  .fifoWrData (fifoWrData),
  .txHalt     (txHalt),
  .txInsValid (txInsValid),
  .txInsChar  (txInsChar),
  .specIrq    (specIrq)
);

// File: tb/test_uart_swflow_ctrl.sv
module test_uart_swflow_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] XON1  = 8'h11;
  localparam logic [7:0] XOFF1 = 8'h13;
  localparam logic [7:0] XON2  = 8'h91;
  localparam logic [7:0] XOFF2 = 8'h93;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxValid = 1'b0;
  logic [7:0] rxData = '0;
  logic [3:0] ctrlMode = '0;
  logic       specialEn = 1'b0;
  logic [4:0] fifoLevel = '0;
  logic [4:0] hiTrig = 5'd12;
  logic [4:0] loTrig = 5'd4;
  logic       specRead = 1'b0;
  logic       txInsReady = 1'b0;
  logic       fifoWrEn;
  logic [7:0] fifoWrData;
  logic       txHalt;
  logic       txInsValid;
  logic [7:0] txInsChar;
  logic       specIrq;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_swflow_ctrl i_uart_swflow_ctrl (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxData(rxData),
    .ctrlMode(ctrlMode), .specialEn(specialEn),
    .xonChar1(XON1), .xonChar2(XON2), .xoffChar1(XOFF1), .xoffChar2(XOFF2),
    .fifoLevel(fifoLevel), .hiTrig(hiTrig), .loTrig(loTrig),
    .specRead(specRead), .txInsReady(txInsReady),
    .fifoWrEn(fifoWrEn), .fifoWrData(fifoWrData), .txHalt(txHalt),
    .txInsValid(txInsValid), .txInsChar(txInsChar), .specIrq(specIrq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one character; returns at the negedge where its write is visible
  task automatic sendChar(input logic [7:0] c);
    @(negedge clk);
    rxData  = c;
    rxValid = 1'b1;
    @(negedge clk);
    rxValid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 fifoWrEn", fifoWrEn, 0);
    chk("R1 txHalt", txHalt, 0);
    chk("R1 txInsValid", txInsValid, 0);
    chk("R1 specIrq", specIrq, 0);
  endtask

  task automatic t_passthrough;
    ctrlMode = 4'b0000;
    sendChar(8'h41);
    chk("R2 wr", fifoWrEn, 1); chk("R2 data", fifoWrData, 8'h41);
    sendChar(XOFF1);
    chk("R2 xoff as data", fifoWrEn, 1); chk("R2 xoff data", fifoWrData, XOFF1);
    chk("R2 no halt", txHalt, 0);
  endtask

  task automatic t_single_pair;
    ctrlMode = 4'b0010;
    sendChar(XOFF1);
    chk("R3 xoff1 consumed", fifoWrEn, 0); chk("R3 halt set", txHalt, 1);
    sendChar(XON2);
    chk("R3 other pair is data", fifoWrEn, 1); chk("R3 data", fifoWrData, XON2);
    chk("R3 halt kept", txHalt, 1);
    sendChar(XON1);
    chk("R3 xon1 consumed", fifoWrEn, 0); chk("R3 halt clear", txHalt, 0);
    ctrlMode = 4'b0001;
    sendChar(XOFF2);
    chk("R3 xoff2 consumed", fifoWrEn, 0); chk("R3 pair2 halt", txHalt, 1);
    sendChar(XON2);
    chk("R3 pair2 clear", txHalt, 0);
  endtask

  task automatic t_both_seq;
    ctrlMode = 4'b0011;
    sendChar(XON2);
    chk("R4 lone second is data", fifoWrEn, 1); chk("R4 lone data", fifoWrData, XON2);
    sendChar(XOFF1);
    chk("R4 first held", fifoWrEn, 0);
    sendChar(XOFF2);
    chk("R4 pair consumed", fifoWrEn, 0); chk("R4 halt set", txHalt, 1);
    sendChar(XON1);
    sendChar(XON2);
    chk("R4 resume consumed", fifoWrEn, 0); chk("R4 halt clear", txHalt, 0);
  endtask

  task automatic t_both_mismatch;
    ctrlMode = 4'b0011;
    sendChar(XON1);
    chk("R5 held", fifoWrEn, 0);
    sendChar(8'h5A);
    chk("R5 held released", fifoWrEn, 1); chk("R5 held data", fifoWrData, XON1);
    @(negedge clk);
    chk("R5 second written", fifoWrEn, 1); chk("R5 second data", fifoWrData, 8'h5A);
    @(negedge clk);
    chk("R5 idle after", fifoWrEn, 0);
  endtask

  task automatic t_halt_off;
    ctrlMode = 4'b0010;
    sendChar(XOFF1);
    chk("R8 halt before", txHalt, 1);
    ctrlMode = 4'b0000;
    @(negedge clk);
    chk("R8 mode 00 clears halt", txHalt, 0);
    ctrlMode = 4'b0010;
    sendChar(XOFF1);
    specialEn = 1'b1;
    @(negedge clk);
    chk("R8 special clears halt", txHalt, 0);
    specialEn = 1'b0;
  endtask

  task automatic t_special;
    ctrlMode = 4'b0000;
    specialEn = 1'b1;
    sendChar(8'h20);
    chk("R6 plain stored", fifoWrEn, 1); chk("R6 no irq", specIrq, 0);
    sendChar(XOFF2);
    chk("R6 match stored", fifoWrEn, 1); chk("R6 match data", fifoWrData, XOFF2);
    chk("R6 irq set", specIrq, 1); chk("R6 no halt", txHalt, 0);
    sendChar(XOFF1);
    chk("R6 xoff1 not consumed", fifoWrEn, 1);
    repeat (3) @(negedge clk);
    chk("R7 irq sticky", specIrq, 1);
    specRead = 1'b1;
    @(negedge clk);
    specRead = 1'b0;
    chk("R7 irq cleared", specIrq, 0);
    @(negedge clk);
    rxData = XOFF2; rxValid = 1'b1; specRead = 1'b1;
    @(negedge clk);
    rxValid = 1'b0; specRead = 1'b0;
    chk("R7 set wins over read", specIrq, 1);
    specRead = 1'b1;
    @(negedge clk);
    specRead = 1'b0;
    specialEn = 1'b0;
  endtask

  task automatic t_tx_both;
    ctrlMode = 4'b1100;
    fifoLevel = 5'd12;
    @(negedge clk);
    chk("R9 request", txInsValid, 1); chk("R9 xoff1", txInsChar, XOFF1);
    @(negedge clk);
    chk("R9 held", txInsValid, 1); chk("R9 held char", txInsChar, XOFF1);
    txInsReady = 1'b1;
    @(negedge clk);
    chk("R9 second", txInsValid, 1); chk("R9 xoff2", txInsChar, XOFF2);
    @(negedge clk);
    txInsReady = 1'b0;
    chk("R9 done", txInsValid, 0);
    repeat (3) @(negedge clk);
    chk("R10 no repeat high", txInsValid, 0);
    fifoLevel = 5'd3;
    @(negedge clk);
    chk("R10 resume", txInsValid, 1); chk("R10 xon1", txInsChar, XON1);
    txInsReady = 1'b1;
    @(negedge clk);
    chk("R10 xon2", txInsChar, XON2);
    @(negedge clk);
    txInsReady = 1'b0;
    chk("R10 done", txInsValid, 0);
    repeat (2) @(negedge clk);
    chk("R10 no repeat low", txInsValid, 0);
  endtask

  task automatic t_tx_single;
    ctrlMode = 4'b1000;
    fifoLevel = 5'd14;
    @(negedge clk);
    chk("R9 mode10 xoff1", txInsChar, XOFF1);
    txInsReady = 1'b1;
    @(negedge clk);
    txInsReady = 1'b0;
    chk("R9 mode10 single", txInsValid, 0);
    ctrlMode = 4'b0100;
    fifoLevel = 5'd1;
    @(negedge clk);
    chk("R10 mode01 xon2", txInsChar, XON2);
    txInsReady = 1'b1;
    @(negedge clk);
    txInsReady = 1'b0;
    chk("R10 mode01 single", txInsValid, 0);
  endtask

  task automatic t_tx_off;
    ctrlMode = 4'b0000;
    fifoLevel = 5'd16;
    repeat (3) @(negedge clk);
    chk("R11 no request", txInsValid, 0);
    fifoLevel = 5'd0;
    repeat (2) @(negedge clk);
    chk("R11 still none", txInsValid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_passthrough();
    t_single_pair();
    t_both_seq();
    t_both_mismatch();
    t_halt_off();
    t_special();
    t_tx_both();
    t_tx_single();
    t_tx_off();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

endmodule